// File: doc/BRIEF.md
# Packed-Word PHY Test Register Port

This block lets software program a small per-port PHY configuration register file through one memory-mapped 24-bit control word. Data byte, register address and port number all share that word with three control bits: a write enable, a software-toggled strobe and an active-low test reset. The block registers the word every system clock and commits a byte write when it sees the strobe go from 0 to 1 in the registered copy, with write enable set and the test reset released.

Software writes the word three times per register update: fields with the strobe low, the same word with the strobe high, then the strobe low again. Exactly one byte is stored per such sequence. One bit of the stored bytes, bit 2 of register 0x06 in port 0, drives a PHY clock-enable output. A combinational readback port returns any stored byte for checking.

Top module: `phy_tstreg_port`

## Requirements
- R1: A commit stores word bits [7:0] as data into register word bits [15:8] of port word bits [18:16]; other registers are unchanged.
- R2: A commit happens only when word bit 22 (strobe) changes from 0 to 1; holding it at 1 or taking it from 1 to 0 stores nothing, so a low-high-low sequence stores exactly one byte.
- R3: When word bit 21 (write enable) is 0, a rising strobe stores nothing.
- R4: While word bit 23 (test reset, active low) is 0, every register reads 0 and no write is stored.
- R5: Only ports 0 and 1 exist; a write naming ports 2 to 7 changes no register and leaves phy_clk_en_o unchanged.
- R6: phy_clk_en_o equals bit 2 of port 0 register 0x06; register 0x06 of port 1 has no effect on it.
- R7: Word bits 19 and 20 have no effect on where or whether a write lands.
- R8: rd_data_o returns, in the same cycle, the byte at rd_port_i/rd_addr_i, and 0 for ports 2 to 7.
- R9: After rst_ni is asserted, all registers read 0 and phy_clk_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | 24 | Software control word |
| rd_port_i | input | 3 | Readback port number |
| rd_addr_i | input | 8 | Readback register address |
| rd_data_o | output | 8 | Readback byte |
| phy_clk_en_o | output | 1 | PHY clock enable from port 0 register 0x06 bit 2 |

## Verification
The edge assertions compare a commit with the strobe and write-enable bits seen on the two preceding clocks at the port, so they take for granted that the control word is all zeros during reset and for the first clock after it. The bench keeps the word at zero through reset and holds every word for two clocks, so each strobe phase is seen by the registered copy. Stimulus sweeps every address of both ports, then drives held strobes, falling strobes, cleared enables, out-of-range ports, set spare bits and a low test reset.

// File: rtl/tstreg_pkg.sv
package tstreg_pkg;
  localparam int WORD_W   = 24;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int PORT_W   = 3;
  localparam int DATA_LSB = 0;
  localparam int ADDR_LSB = 8;
  localparam int PORT_LSB = 16;
  localparam int WREN_BIT = 21;
  localparam int STRB_BIT = 22;
  localparam int TRST_BIT = 23;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/tstreg_decode.sv
module tstreg_decode
  import tstreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output wr_req_t           req_o,
  output logic              commit_o,
  output logic              trst_n_o
);
  wr_req_t req_q;
  logic    wren_q, strb_q, strb_prev_q, trst_n_q;
  logic    unused_spare;

  assign unused_spare = ^word_i[WREN_BIT-1:PORT_LSB+PORT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= '0;
      wren_q      <= 1'b0;
      strb_q      <= 1'b0;
      strb_prev_q <= 1'b0;
      trst_n_q    <= 1'b0;
    end else begin
      req_q.data  <= word_i[DATA_LSB +: DATA_W];
      req_q.addr  <= word_i[ADDR_LSB +: ADDR_W];
      req_q.port  <= word_i[PORT_LSB +: PORT_W];
      wren_q      <= word_i[WREN_BIT];
      strb_q      <= word_i[STRB_BIT];
      strb_prev_q <= strb_q;
      trst_n_q    <= word_i[TRST_BIT];
    end
  end

  // edge seen on the registered copy only
  assign commit_o = strb_q & ~strb_prev_q & wren_q & trst_n_q;
  assign req_o    = req_q;
  assign trst_n_o = trst_n_q;
endmodule

// File: rtl/tstreg_bank.sv
module tstreg_bank
  import tstreg_pkg::*;
#(
  parameter int PORT_ID  = 0,
  parameter bit TAP_EN   = 1'b0,
  parameter int TAP_ADDR = 6,
  parameter int TAP_BIT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  wr_req_t           req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tap_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PORT_W-1:0] PID = PORT_W'(PORT_ID);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              hit;

  assign hit = we_i && (req_i.port == PID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (hit) begin
      mem_q[req_i.addr] <= req_i.data;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  generate
    if (TAP_EN) begin : g_tap
      assign tap_o = mem_q[TAP_ADDR][TAP_BIT];
    end else begin : g_no_tap
      assign tap_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/phy_tstreg_port.sv
module phy_tstreg_port
  import tstreg_pkg::*;
#(
  parameter int N_PORTS     = 2,
  parameter int CLKEN_PORT  = 0,
  parameter int CLKEN_ADDR  = 6,
  parameter int CLKEN_BIT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ctrl_word_i,
  input  logic [PORT_W-1:0] rd_port_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              phy_clk_en_o
);
  wr_req_t           req;
  logic              commit;
  logic              trst_n;
  logic [DATA_W-1:0] bank_rd [N_PORTS];
  logic [N_PORTS-1:0] tap_bits;

  tstreg_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (ctrl_word_i),
    .req_o    (req),
    .commit_o (commit),
    .trst_n_o (trst_n)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_bank
    tstreg_bank #(
      .PORT_ID  (p),
      .TAP_EN   (p == CLKEN_PORT),
      .TAP_ADDR (CLKEN_ADDR),
      .TAP_BIT  (CLKEN_BIT)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (~trst_n),
      .we_i      (commit),
      .req_i     (req),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (bank_rd[p]),
      .tap_o     (tap_bits[p])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (int'(rd_port_i) == p) rd_data_o = bank_rd[p];
  end

  assign phy_clk_en_o = |tap_bits;
endmodule

// File: rtl/tstreg_chk.sv
module tstreg_chk #(
  parameter int N_PORTS = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wren_i,
  input logic       strb_i,
  input logic       commit_i,
  input logic [2:0] port_i,
  input logic       trst_n_i,
  input logic [2:0] rd_port_i,
  input logic [7:0] rd_data_i,
  input logic       clk_en_i
);
  // R2
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> !commit_i);
  // R2
  commit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> ($past(strb_i) && !$past(strb_i, 2)));
  // R3
  commit_wren_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(wren_i));
  // R4
  trst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trst_n_i |=> !clk_en_i);
  // R5
  bad_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && int'(port_i) >= N_PORTS) |=> $stable(clk_en_i));
  // R6
  clken_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && trst_n_i) |=> $stable(clk_en_i));
  // R8
  rd_bad_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_port_i) >= N_PORTS) |-> (rd_data_i == 8'h00));
endmodule

bind phy_tstreg_port tstreg_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wren_i    (ctrl_word_i[21]),
  .strb_i    (ctrl_word_i[22]),
  .commit_i  (commit),
  .port_i    (req.port),
  .trst_n_i  (trst_n),
  .rd_port_i (rd_port_i),
  .rd_data_i (rd_data_o),
  .clk_en_i  (phy_clk_en_o)
);

// File: tb/sim_phy_tstreg_port.sv
module sim_phy_tstreg_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] ctrl_word = '0;
  logic [2:0]  rd_port = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        clk_en;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_tstreg_port u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_word_i  (ctrl_word),
    .rd_port_i    (rd_port),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .phy_clk_en_o (clk_en)
  );

  function automatic logic [7:0] pat(int p, int a);
    return 8'((a * 37 + p * 101 + 5) & 255);
  endfunction

  function automatic logic [23:0] mk(bit trst, bit strb, bit we, logic [1:0] sp,
                                     logic [2:0] p, logic [7:0] a, logic [7:0] d);
    return {trst, strb, we, sp, p, a, d};
  endfunction

  task automatic put(logic [23:0] w, int n);
    ctrl_word = w;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_seq(bit trst, bit we, logic [1:0] sp, logic [2:0] p,
                        logic [7:0] a, logic [7:0] d);
    put(mk(trst, 1'b0, we, sp, p, a, d), 2);
    put(mk(trst, 1'b1, we, sp, p, a, d), 2);
    put(mk(trst, 1'b0, we, sp, p, a, d), 2);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, int p, int a, logic [7:0] exp);
    rd_port = 3'(p);
    rd_addr = 8'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    rd_chk("R9", 0, 6, 8'h00);
    rd_chk("R9", 1, 255, 8'h00);
    chk("R9", {7'b0, clk_en}, 8'h00);

    // R1 sweep of every register of both ports
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 256; a++)
        wr_seq(1'b1, 1'b1, 2'b00, 3'(p), 8'(a), pat(p, a));
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 256; a++)
        rd_chk("R1", p, a, pat(p, a));
    // R6 tap follows swept value
    chk("R6", {7'b0, clk_en}, {7'b0, pat(0, 6)[2]});

    // R8 out-of-range ports read zero
    for (int p = 2; p < 8; p++) rd_chk("R8", p, 8'h40, 8'h00);

    // R2 held high and falling strobe store nothing more
    put(mk(1, 0, 1, 0, 0, 8'h10, 8'h11), 2);
    put(mk(1, 1, 1, 0, 0, 8'h10, 8'h11), 2);
    rd_chk("R2", 0, 8'h10, 8'h11);
    put(mk(1, 1, 1, 0, 0, 8'h10, 8'h22), 3);
    rd_chk("R2", 0, 8'h10, 8'h11);
    put(mk(1, 0, 1, 0, 0, 8'h10, 8'h33), 3);
    rd_chk("R2", 0, 8'h10, 8'h11);

    // R3 write enable low
    wr_seq(1'b1, 1'b0, 2'b00, 3'd1, 8'h20, 8'hA5);
    rd_chk("R3", 1, 8'h20, pat(1, 8'h20));

    // R7 spare bits set
    wr_seq(1'b1, 1'b1, 2'b11, 3'd1, 8'h77, 8'h5A);
    rd_chk("R7", 1, 8'h77, 8'h5A);
    rd_chk("R7", 0, 8'h77, pat(0, 8'h77));

    // R6 clock enable
    wr_seq(1'b1, 1'b1, 2'b00, 3'd0, 8'h06, 8'h04);
    chk("R6", {7'b0, clk_en}, 8'h01);
    wr_seq(1'b1, 1'b1, 2'b00, 3'd1, 8'h06, 8'h00);
    chk("R6", {7'b0, clk_en}, 8'h01);
    wr_seq(1'b1, 1'b1, 2'b00, 3'd0, 8'h06, 8'hFB);
    chk("R6", {7'b0, clk_en}, 8'h00);
    wr_seq(1'b1, 1'b1, 2'b00, 3'd1, 8'h06, 8'h04);
    chk("R6", {7'b0, clk_en}, 8'h00);
    wr_seq(1'b1, 1'b1, 2'b00, 3'd0, 8'h06, 8'h04);

    // R5 writes to absent ports
    for (int p = 2; p < 8; p++) begin
      wr_seq(1'b1, 1'b1, 2'b00, 3'(p), 8'h06, 8'h00);
      wr_seq(1'b1, 1'b1, 2'b00, 3'(p), 8'h40, 8'hEE);
      chk("R5", {7'b0, clk_en}, 8'h01);
      rd_chk("R5", 0, 8'h40, pat(0, 8'h40));
      rd_chk("R5", 1, 8'h40, pat(1, 8'h40));
      rd_chk("R5", 0, 8'h06, 8'h04);
    end

    // R4 test reset low clears and blocks writes
    put(mk(0, 0, 0, 0, 0, 0, 0), 2);
    rd_chk("R4", 0, 8'h06, 8'h00);
    rd_chk("R4", 1, 8'h40, 8'h00);
    chk("R4", {7'b0, clk_en}, 8'h00);
    wr_seq(1'b0, 1'b1, 2'b00, 3'd0, 8'h30, 8'h99);
    rd_chk("R4", 0, 8'h30, 8'h00);
    put(mk(1, 0, 0, 0, 0, 0, 0), 2);
    rd_chk("R4", 0, 8'h30, 8'h00);
    rd_chk("R4", 0, 8'h10, 8'h00);
    wr_seq(1'b1, 1'b1, 2'b00, 3'd0, 8'h30, 8'h99);
    rd_chk("R4", 0, 8'h30, 8'h99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule